// File: doc/BRIEF.md
# Strobed Register Port with Acknowledge Handshake

This block is the slave side of an 8-bit parallel processor bus that controls a motor-control peripheral. The processor first presents a 3-bit register number and pulses an active-low address strobe. The block captures the number on the strobe's falling edge. A cycle then begins when the active-low chip select is low and either the active-low read strobe or the active-low write strobe falls. The block, not the processor, decides how long the cycle lasts. It pulls an active-low, open-drain acknowledge line once the data is on the bus (for a read) or stored (for a write). It lets the line go only after the processor raises its strobe.

All strobes are asynchronous to the system clock. They pass through synchronizer stages before any edge is detected, so every response has a fixed latency counted in system clocks. The block holds seven registers: a live status view, actuator and spindle control words, two converter codes, an interrupt mask, and a phase-delay word. It also drives an open-drain error line from the status flags that are not masked. The open-drain outputs are modelled as "pull low" enables, and the bidirectional data bus is split into an input, an output and an output enable.

Top module: `pbus_slave`

## Requirements
- R1: The register number on `addr` is captured at the third rising clock edge at which `as_n` is sampled low (two synchronizer stages plus one edge-detect edge). Later changes on `addr` do not affect a cycle until the next address strobe.
- R2: A cycle starts only when `cs_n` is low and the captured number is non-zero when a read or write strobe fall is detected. `ack_drive_low` goes high at the fourth rising edge at which that strobe is sampled low. If both strobes fall together, the read wins.
- R3: On a read, `data_oe` goes high at the third edge at which `rd_n` is sampled low, one clock before the acknowledge. `data_out` then carries the selected register as it was at that edge. While `data_oe` is low, `data_out` is zero.
- R4: Once the acknowledge is active, `ack_drive_low` and `data_oe` stay high until both strobes have been sampled high at three consecutive edges. Both fall at that third edge.
- R5: On a write, the register is loaded at the third edge at which `wr_n` is sampled low, from `data_in` ANDed with its writable-bit mask. The map is: 2 actuator control (bits 4:0), 3 spindle control (bits 6:0), 4 actuator code (7:0), 5 spindle code (7:0), 6 interrupt mask (2:0), 7 phase delay (3:0).
- R6: A read or write strobe with `cs_n` high, or with captured address 0, produces no acknowledge, no data drive and no register change.
- R7: Reset clears every register, the captured address, the acknowledge, the data enable and the error line. Bits outside a register's writable mask always read as zero.
- R8: Address 1 reads `{4'b0000, flags}` as sampled at the read's third low edge. Writes to address 1 change nothing.
- R9: `err_drive_low` is registered. At each edge it takes the value of OR over i in 0..2 of `flags[i] AND NOT mask[i]`, where mask bit i set to 1 suppresses flag i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| as_n | input | 1 | Address strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register number |
| data_in | input | 8 | Bus data seen by the block |
| data_out | output | 8 | Bus data driven by the block |
| data_oe | output | 1 | Enable for the data bus driver |
| ack_drive_low | output | 1 | 1 pulls the acknowledge line low |
| flags | input | 4 | Live status flags |
| err_drive_low | output | 1 | 1 pulls the error line low |
| act_ctrl | output | 5 | Actuator control word |
| spin_ctrl | output | 7 | Spindle control word |
| act_dac | output | 8 | Actuator converter code |
| spin_dac | output | 8 | Spindle converter code |
| phase_dly | output | 4 | Commutation phase delay |

## Verification
The hardest case to reach is a cycle whose address came from an earlier strobe while the live `addr` pins already show a different value. A read must then return the register that was latched, not the one on the pins. The bench produces this by running an address phase and then changing `addr` with no new strobe before pulsing the read strobe. It also runs cycles with chip select high and with address 0 placed between real cycles, so a spurious acknowledge or write would show up against the per-clock model.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int FW = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_DRIVE, PH_ACK} phase_e;

  localparam logic [AW-1:0] A_STAT = 3'd1;
  localparam logic [AW-1:0] A_ACT  = 3'd2;
  localparam logic [AW-1:0] A_SPIN = 3'd3;
  localparam logic [AW-1:0] A_ADAC = 3'd4;
  localparam logic [AW-1:0] A_SDAC = 3'd5;
  localparam logic [AW-1:0] A_MASK = 3'd6;
  localparam logic [AW-1:0] A_PDLY = 3'd7;

  // Writable bits of each register; zero means read-only or absent.
  function automatic logic [DW-1:0] wr_mask(input logic [AW-1:0] a);
    case (a)
      A_ACT:   wr_mask = 8'h1F;
      A_SPIN:  wr_mask = 8'h7F;
      A_ADAC:  wr_mask = 8'hFF;
      A_SDAC:  wr_mask = 8'hFF;
      A_MASK:  wr_mask = 8'h07;
      A_PDLY:  wr_mask = 8'h0F;
      default: wr_mask = 8'h00;
    endcase
  endfunction

  // Error line: any flag among the low three whose mask bit is clear.
  function automatic logic err_of(input logic [FW-1:0] f, input logic [DW-1:0] m);
    err_of = |(f[2:0] & ~m[2:0]);
  endfunction
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], din[i]};
    end
    assign dout[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_s,
  input  logic          wr_s,
  input  logic          as_s,
  input  logic          cs_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q,
  output logic          rd_go,
  output logic          wr_go,
  output logic          ack_pull,
  output logic          oe
);
  logic   rd_d, wr_d, as_d;
  phase_e ph;
  logic   rd_fall, wr_fall, as_fall, sel, rel_go;

  assign rd_fall = rd_d & ~rd_s;
  assign wr_fall = wr_d & ~wr_s;
  assign as_fall = as_d & ~as_s;
  assign sel     = ~cs_n & (addr_q != '0);
  assign rd_go   = (ph == PH_IDLE) & rd_fall & sel;
  assign wr_go   = (ph == PH_IDLE) & wr_fall & ~rd_fall & sel;
  assign rel_go  = (ph == PH_ACK) & rd_s & wr_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_d     <= 1'b1;
      wr_d     <= 1'b1;
      as_d     <= 1'b1;
      addr_q   <= '0;
      ph       <= PH_IDLE;
      ack_pull <= 1'b0;
      oe       <= 1'b0;
    end else begin
      rd_d <= rd_s;
      wr_d <= wr_s;
      as_d <= as_s;
      if (as_fall) addr_q <= addr_in;
      case (ph)
        PH_IDLE: begin
          if (rd_go) begin
            ph <= PH_DRIVE;
            oe <= 1'b1;
          end else if (wr_go) begin
            ph <= PH_DRIVE;
          end
        end
        PH_DRIVE: begin
          ph       <= PH_ACK;
          ack_pull <= 1'b1;
        end
        PH_ACK: begin
          if (rel_go) begin
            ph       <= PH_IDLE;
            ack_pull <= 1'b0;
            oe       <= 1'b0;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_pull) |-> $past(!(rd_s && wr_s))); // R2
  AST_DATA_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_pull) |-> ($past(oe) == oe)); // R3
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pull && !(rd_s && wr_s)) |=> ack_pull); // R4
  AST_RELEASE_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_pull) |-> ($past(rd_s && wr_s) && !oe)); // R4
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_go, wr_go})); // R2
endmodule

// File: rtl/pbus_regs.sv
module pbus_regs
  import pbus_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_go,
  input  logic          rd_go,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] wdata,
  input  logic [FW-1:0] flags,
  output logic [DW-1:0] rdata_q,
  output logic          err_pull,
  output logic [DW-1:0] act_q,
  output logic [DW-1:0] spin_q,
  output logic [DW-1:0] adac_q,
  output logic [DW-1:0] sdac_q,
  output logic [DW-1:0] pdly_q
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0]      regs [NREG];
  logic [NREG*DW-1:0] all_regs;
  logic [DW-1:0]      rd_val;

  for (genvar a = 0; a < NREG; a++) begin : g_reg
    localparam logic [DW-1:0] WM = wr_mask(AW'(a));
    if (WM != '0) begin : g_rw
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          q <= '0;
        else if (wr_go && addr_q == AW'(a))  q <= wdata & WM;
      end
      assign regs[a] = q;
    end else begin : g_ro
      assign regs[a] = '0;
    end
    assign all_regs[a*DW +: DW] = regs[a];
  end

  assign rd_val = (addr_q == A_STAT) ? DW'(flags) : regs[addr_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      err_pull <= 1'b0;
    end else begin
      if (rd_go) rdata_q <= rd_val;
      err_pull <= err_of(flags, regs[A_MASK]);
    end
  end

  assign act_q  = regs[A_ACT];
  assign spin_q = regs[A_SPIN];
  assign adac_q = regs[A_ADAC];
  assign sdac_q = regs[A_SDAC];
  assign pdly_q = regs[A_PDLY];

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> $stable(all_regs)); // R6
  AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q[7:5] == '0) && (spin_q[7] == 1'b0) && (pdly_q[7:4] == '0)); // R7
endmodule

// File: rtl/pbus_slave.sv
module pbus_slave
  import pbus_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          as_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          ack_drive_low,
  input  logic [FW-1:0] flags,
  output logic          err_drive_low,
  output logic [4:0]    act_ctrl,
  output logic [6:0]    spin_ctrl,
  output logic [DW-1:0] act_dac,
  output logic [DW-1:0] spin_dac,
  output logic [3:0]    phase_dly
);
  logic [2:0]    strb_s;
  logic [AW-1:0] addr_q;
  logic          rd_go, wr_go;
  logic [DW-1:0] rdata_q, act_q, spin_q, pdly_q;

  pbus_sync #(.W(3), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({as_n, wr_n, rd_n}),
    .dout (strb_s)
  );

  pbus_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_s    (strb_s[0]),
    .wr_s    (strb_s[1]),
    .as_s    (strb_s[2]),
    .cs_n    (cs_n),
    .addr_in (addr),
    .addr_q  (addr_q),
    .rd_go   (rd_go),
    .wr_go   (wr_go),
    .ack_pull(ack_drive_low),
    .oe      (data_oe)
  );

  pbus_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_go   (wr_go),
    .rd_go   (rd_go),
    .addr_q  (addr_q),
    .wdata   (data_in),
    .flags   (flags),
    .rdata_q (rdata_q),
    .err_pull(err_drive_low),
    .act_q   (act_q),
    .spin_q  (spin_q),
    .adac_q  (act_dac),
    .sdac_q  (spin_dac),
    .pdly_q  (pdly_q)
  );

  assign data_out  = data_oe ? rdata_q : '0;
  assign act_ctrl  = act_q[4:0];
  assign spin_ctrl = spin_q[6:0];
  assign phase_dly = pdly_q[3:0];
endmodule

// File: tb/pbus_slave_bench.sv
module pbus_slave_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       as_n = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] data_in = '0;
  logic [3:0] flags = '0;
  logic [7:0] data_out, act_dac, spin_dac;
  logic       data_oe, ack_drive_low, err_drive_low;
  logic [4:0] act_ctrl;
  logic [6:0] spin_ctrl;
  logic [3:0] phase_dly;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  pbus_slave u_pbus_slave (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .ack_drive_low(ack_drive_low), .flags(flags), .err_drive_low(err_drive_low),
    .act_ctrl(act_ctrl), .spin_ctrl(spin_ctrl), .act_dac(act_dac),
    .spin_dac(spin_dac), .phase_dly(phase_dly)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // Behavioural reference: strobe low/high run lengths in clock edges.
  int   rd_lo, rd_hi, wr_lo, wr_hi, as_lo, as_hi, ph;
  int   m_reg [8];
  int   m_addr;
  bit   e_ack, e_oe, e_err;
  int   e_data;

  function automatic int writable(input int a);
    case (a)
      2: return 'h1F;  3: return 'h7F;  4: return 'hFF;
      5: return 'hFF;  6: return 'h07;  7: return 'h0F;
      default: return 0;
    endcase
  endfunction

  function automatic int bump(input int v);
    return (v < 100) ? v + 1 : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_lo = 0; wr_lo = 0; as_lo = 0; rd_hi = 100; wr_hi = 100; as_hi = 100;
      ph = 0; m_addr = 0; e_ack = 0; e_oe = 0; e_err = 0; e_data = 0;
      foreach (m_reg[i]) m_reg[i] = 0;
    end else begin
      e_err = ((flags[0] && !m_reg[6][0]) || (flags[1] && !m_reg[6][1]) ||
               (flags[2] && !m_reg[6][2]));
      if (rd_n) begin rd_hi = bump(rd_hi); rd_lo = 0; end else begin rd_lo = bump(rd_lo); rd_hi = 0; end
      if (wr_n) begin wr_hi = bump(wr_hi); wr_lo = 0; end else begin wr_lo = bump(wr_lo); wr_hi = 0; end
      if (as_n) begin as_hi = bump(as_hi); as_lo = 0; end else begin as_lo = bump(as_lo); as_hi = 0; end
      case (ph)
        0: begin
          if (rd_lo == 3 && !cs_n && m_addr != 0) begin
            ph = 1; e_oe = 1;
            e_data = (m_addr == 1) ? int'(flags) : m_reg[m_addr];
          end else if (wr_lo == 3 && rd_lo != 3 && !cs_n && m_addr != 0) begin
            ph = 1;
            m_reg[m_addr] = int'(data_in) & writable(m_addr);
          end
        end
        1: begin ph = 2; e_ack = 1; end
        default: if (rd_hi >= 3 && wr_hi >= 3) begin ph = 0; e_ack = 0; e_oe = 0; end
      endcase
      if (as_lo == 3) m_addr = int'(addr);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ack_drive_low == e_ack, "R2/R4 ack", ack_drive_low, e_ack);
      chk(data_oe == e_oe, "R3/R4 data_oe", data_oe, e_oe);
      chk(int'(data_out) == (e_oe ? e_data : 0), "R3 data_out", data_out, e_oe ? e_data : 0);
      chk(int'(act_ctrl) == m_reg[2] && int'(spin_ctrl) == m_reg[3], "R5 ctrl words",
          {act_ctrl, spin_ctrl}, {m_reg[2][4:0], m_reg[3][6:0]});
      chk(int'(act_dac) == m_reg[4] && int'(spin_dac) == m_reg[5] && int'(phase_dly) == m_reg[7],
          "R5 codes", {act_dac, spin_dac, phase_dly}, {m_reg[4][7:0], m_reg[5][7:0], m_reg[7][3:0]});
      chk(err_drive_low == e_err, "R9 err", err_drive_low, e_err);
    end
  end

  task automatic addr_phase(input logic [2:0] a);
    @(negedge clk); addr = a; as_n = 1'b0;
    repeat (4) @(negedge clk);
    as_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_phase(input logic sel, output logic [7:0] d, output bit acked);
    acked = 0; d = '0;
    @(negedge clk); cs_n = !sel; rd_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ack_drive_low && !acked) begin acked = 1; d = data_out; end
    end
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_read(input logic [2:0] a, input logic sel, output logic [7:0] d, output bit acked);
    addr_phase(a);
    rd_phase(sel, d, acked);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic sel, input logic [7:0] v, output bit acked);
    addr_phase(a);
    acked = 0;
    @(negedge clk); cs_n = !sel; data_in = v; wr_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ack_drive_low) acked = 1;
    end
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    bit ak;
    logic [7:0] exp_rb [8];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: reset state at the ports
    chk({ack_drive_low, data_oe, err_drive_low} == 3'b000, "R7 reset handshake", {ack_drive_low, data_oe, err_drive_low}, 0);
    chk({act_ctrl, spin_ctrl, act_dac, spin_dac, phase_dly} == '0, "R7 reset registers",
        {act_ctrl, spin_ctrl, act_dac, spin_dac, phase_dly}, 0);

    flags = 4'hA;
    // R8: status view; R7: other registers read zero after reset
    bus_read(3'd1, 1'b1, d, ak);
    chk(ak && d == 8'h0A, "R8 status read", d, 8'h0A);
    for (int a = 2; a < 8; a++) begin
      bus_read(3'(a), 1'b1, d, ak);
      chk(ak && d == 8'h00, "R7 reset readback", d, 0);
    end

    // R5: writes through each register's mask and readback
    exp_rb[2] = 8'h1F; exp_rb[3] = 8'h7F; exp_rb[4] = 8'h81;
    exp_rb[5] = 8'h3C; exp_rb[6] = 8'h07; exp_rb[7] = 8'h05;
    bus_write(3'd2, 1'b1, 8'hFF, ak); chk(ak, "R5 write ack", ak, 1);
    bus_write(3'd3, 1'b1, 8'hFF, ak);
    bus_write(3'd4, 1'b1, 8'h81, ak);
    bus_write(3'd5, 1'b1, 8'h3C, ak);
    bus_write(3'd6, 1'b1, 8'hFF, ak);
    bus_write(3'd7, 1'b1, 8'hA5, ak);
    for (int a = 2; a < 8; a++) begin
      bus_read(3'(a), 1'b1, d, ak);
      chk(ak && d == exp_rb[a], "R5 R7 masked readback", d, exp_rb[a]);
    end

    // R8: write to status has no effect
    bus_write(3'd1, 1'b1, 8'hFF, ak);
    bus_read(3'd1, 1'b1, d, ak);
    chk(d == 8'h0A, "R8 status write ignored", d, 8'h0A);

    // R9: flag 1 masked, then unmasked
    @(negedge clk); flags = 4'b0010;
    repeat (2) @(negedge clk);
    chk(err_drive_low == 1'b0, "R9 masked flag", err_drive_low, 0);
    bus_write(3'd6, 1'b1, 8'h05, ak);
    chk(err_drive_low == 1'b1, "R9 unmasked flag", err_drive_low, 1);

    // R6: deselected write, address 0 read
    bus_write(3'd4, 1'b0, 8'h00, ak);
    chk(!ak, "R6 deselected write no ack", ak, 0);
    chk(act_dac == 8'h81, "R6 deselected write no change", act_dac, 8'h81);
    bus_read(3'd0, 1'b1, d, ak);
    chk(!ak, "R6 address 0 no ack", ak, 0);
    bus_write(3'd0, 1'b1, 8'h55, ak);
    chk(!ak, "R6 address 0 write no ack", ak, 0);

    // R1: latched address wins over live pins
    addr_phase(3'd4);
    @(negedge clk); addr = 3'd5;
    rd_phase(1'b1, d, ak);
    chk(ak && d == 8'h81, "R1 latched address", d, 8'h81);
    @(negedge clk); data_in = 8'h99;
    // R2: simultaneous strobes take the read
    addr_phase(3'd5);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
    repeat (8) @(negedge clk);
    chk(data_oe == 1'b1 && data_out == 8'h3C, "R2 read priority", data_out, 8'h3C);
    rd_n = 1'b1; wr_n = 1'b1; cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(spin_dac == 8'h3C, "R2 no write on tie", spin_dac, 8'h3C);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule